// File: doc/BRIEF.md
# Dual-SAR Conversion and Readout Logic

This block is the digital core of a four-channel ADC built from two successive-approximation converters that sample at the same instant. A falling edge on the active-low convert-start strobe puts both converters into hold and raises the busy flag. The next rising edge of the external conversion clock starts a conversion of sixteen conversion-clock cycles. That edge also latches the channel-pair address: low selects channel 0 of both converters, high selects channel 1. Each converter resolves one bit per conversion-clock rise, most significant bit first, from its own comparator-decision input. The analog front end is replaced by these per-converter decision inputs.

Four result registers, one per converter per channel pair, hold the codes in 12-bit two's complement. They are written only when a conversion completes. A host reads them over a parallel bus that is driven only while chip-select and read are both low. The first read strobe after a convert-start returns the A converter and the second returns the B converter. During a read, the address bit selects which stored channel pair is presented. All inputs are sampled on the system clock `clk_i`. Edges on the strobes and on the conversion clock are detected against their previous samples.

Top module: `twin_sar_adc`

## Requirements
- R1: After reset, busy_o is low, all four result registers read as 0x000, and the next read returns the A converter.
- R2: busy_o goes high one system clock after a convert-start falling edge is seen and stays high until the 16th conversion-clock rise, counting the rise that starts the conversion; it is low one system clock after that rise.
- R3: The address level present at the first conversion-clock rise after convert-start (not at the convert-start edge) selects the pair written: 0 stores channel-0 results, 1 stores channel-1 results.
- R4: At conversion-clock rise k (k = 1..12) the comparator input sets offset-binary bit 12-k of that converter (1 = keep the bit). Comparator values at rises 13..16 have no effect on the result.
- R5: The stored code is the offset-binary value with its MSB inverted, so that all-ones decisions give 0x7FF, all-zeros give 0x800, only the MSB set gives 0x000, and only the MSB clear gives 0xFFF.
- R6: data_o is driven only while cs_ni and rd_ni are both low; otherwise it is high-impedance.
- R7: The first read after a convert-start returns the A converter, the second returns B, and the third returns A again. A read ends on the rising edge of rd_ni while cs_ni is low.
- R8: Every convert-start falling edge returns the read order to the A converter, even if the B result has not yet been read.
- R9: During a read, a0_i = 0 presents the channel-0 results and a0_i = 1 presents the channel-1 results. A conversion of one pair leaves the other pair's results unchanged.
- R10: Result registers change only at the end of a conversion. Reads made while a conversion runs return the previous results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| convst_ni | input | 1 | Convert-start strobe, active low; falling edge starts a sample |
| conv_clk_i | input | 1 | External conversion clock, sampled on clk_i |
| a0_i | input | 1 | Channel-pair address, used at conversion start and during reads |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| cmp_a_i | input | 1 | Comparator decision for converter A |
| cmp_b_i | input | 1 | Comparator decision for converter B |
| busy_o | output | 1 | High while a sample or conversion is in progress |
| data_o | output | 12 | Tri-state result bus, two's complement |

## Verification
Conversions are driven with comparator patterns that map to the four code-table extremes and to two irregular codes. This shows that the MSB inversion is correct and that each decision lands in the bit the MSB-first schedule assigns to it. Decisions held at one during the four tail rises show that those rises are ignored. The A and B converters receive different patterns in every run, so a swapped read order or a swapped write shows up at once. Further tests change the address between the convert-start edge and the first conversion-clock rise, read in the middle of a running conversion after a half-finished read sequence, and check that the other pair keeps its results.

// File: rtl/twin_sar_pkg.sv
package twin_sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/twin_sar_seq.sv
module twin_sar_seq
  import twin_sar_pkg::*;
#(
  parameter int DW          = 12,
  parameter int CONV_CYCLES = 16,
  localparam int CW = $clog2(CONV_CYCLES + 1),
  localparam int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          convst_ni,
  input  logic          conv_clk_i,
  input  logic          a0_i,
  output logic          busy_o,
  output logic          start_o,
  output logic          dec_en_o,
  output logic [IW-1:0] dec_idx_o,
  output logic          done_o,
  output logic          pair_o
);
  localparam logic [CW-1:0] LAST_C = CW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] DW_C   = CW'(DW);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] step;
  logic [CW-1:0] idx_full;
  logic          convst_q, cclk_q, busy_q, pair_q, rise, active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      convst_q <= 1'b1;
      cclk_q   <= 1'b0;
    end else begin
      convst_q <= convst_ni;
      cclk_q   <= conv_clk_i;
    end
  end

  assign start_o = convst_q & ~convst_ni;
  assign rise    = conv_clk_i & ~cclk_q;
  assign active  = (state_q == ST_HOLD) || (state_q == ST_CONV);

  // number of the conversion-clock rise being taken now (1..CONV_CYCLES)
  assign step      = (state_q == ST_HOLD) ? CW'(1) : cnt_q + CW'(1);
  assign idx_full  = DW_C - step;
  assign dec_en_o  = rise && active && !start_o && (step <= DW_C);
  assign dec_idx_o = idx_full[IW-1:0];
  assign done_o    = rise && !start_o && (state_q == ST_CONV) && (cnt_q == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      pair_q  <= 1'b0;
    end else if (start_o) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
    end else if (rise) begin
      unique case (state_q)
        ST_HOLD: begin
          state_q <= ST_CONV;
          cnt_q   <= CW'(1);
          pair_q  <= a0_i;
        end
        ST_CONV: begin
          if (cnt_q == LAST_C) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign busy_o = busy_q;
  assign pair_o = pair_q;

  AST_BUSY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> busy_o);  // R2
  AST_BUSY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);  // R2
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(CONV_CYCLES));  // R2
endmodule

// File: rtl/twin_sar_sar.sv
module twin_sar_sar #(
  parameter int DW = 12,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [IW-1:0] idx_i,
  input  logic          cmp_i,
  output logic [DW-1:0] bits_o
);
  logic [DW-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bits_q <= '0;
    else if (clr_i)  bits_q <= '0;
    else if (en_i)   bits_q[idx_i] <= cmp_i;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/twin_sar_bank.sv
module twin_sar_bank #(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          pair_i,
  input  logic [DW-1:0] bits_a_i,
  input  logic [DW-1:0] bits_b_i,
  input  logic          start_i,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          a0_i,
  output logic [DW-1:0] data_o
);
  localparam logic [DW-1:0] MSB_C = {1'b1, {(DW-1){1'b0}}};

  // [converter][pair]
  logic [1:0][1:0][DW-1:0] res_q;
  logic                    ord_q, rd_q, cs_q, rd_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b1;
      cs_q <= 1'b1;
    end else begin
      rd_q <= rd_ni;
      cs_q <= cs_ni;
    end
  end

  assign rd_end = rd_ni & ~rd_q & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ord_q <= 1'b0;
    else if (start_i)  ord_q <= 1'b0;
    else if (rd_end)   ord_q <= ~ord_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else if (wr_i) begin
      res_q[0][pair_i] <= bits_a_i ^ MSB_C;
      res_q[1][pair_i] <= bits_b_i ^ MSB_C;
    end
  end

  assign data_o = (!cs_ni && !rd_ni) ? res_q[ord_q][a0_i] : {DW{1'bz}};

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(res_q));  // R10
  AST_ORDER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ord_q);  // R8
endmodule

// File: rtl/twin_sar_adc.sv
module twin_sar_adc #(
  parameter int DW          = 12,
  parameter int CONV_CYCLES = 16,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          convst_ni,
  input  logic          conv_clk_i,
  input  logic          a0_i,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          cmp_a_i,
  input  logic          cmp_b_i,
  output logic          busy_o,
  output logic [DW-1:0] data_o
);
  logic          start, dec_en, done, pair;
  logic [IW-1:0] dec_idx;
  logic [1:0]    cmp;
  logic [DW-1:0] bits [2];

  assign cmp = {cmp_b_i, cmp_a_i};

  twin_sar_seq #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) i_seq (
    .clk_i, .rst_ni, .convst_ni, .conv_clk_i, .a0_i,
    .busy_o, .start_o(start), .dec_en_o(dec_en), .dec_idx_o(dec_idx),
    .done_o(done), .pair_o(pair)
  );

  for (genvar g = 0; g < 2; g++) begin : g_sar
    twin_sar_sar #(.DW(DW)) i_sar (
      .clk_i, .rst_ni, .clr_i(start), .en_i(dec_en), .idx_i(dec_idx),
      .cmp_i(cmp[g]), .bits_o(bits[g])
    );
  end

  twin_sar_bank #(.DW(DW)) i_bank (
    .clk_i, .rst_ni, .wr_i(done), .pair_i(pair),
    .bits_a_i(bits[0]), .bits_b_i(bits[1]), .start_i(start),
    .cs_ni, .rd_ni, .a0_i, .data_o
  );

  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> busy_o);  // R10
endmodule

// File: tb/test_twin_sar_adc.sv
module test_twin_sar_adc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        convst_n = 1'b1, conv_clk = 1'b0, a0 = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, cmp_a = 1'b0, cmp_b = 1'b0;
  logic        busy;
  wire  [11:0] data_w;
  int          n_checks = 0;
  int          n_errors = 0;

  always #5 clk = ~clk;

  twin_sar_adc i_twin_sar_adc (
    .clk_i(clk), .rst_ni(rst_n), .convst_ni(convst_n), .conv_clk_i(conv_clk),
    .a0_i(a0), .cs_ni(cs_n), .rd_ni(rd_n), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b),
    .busy_o(busy), .data_o(data_w)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cc_edge(input logic ca, input logic cb);
    @(negedge clk); cmp_a = ca; cmp_b = cb; conv_clk = 1'b1;
    @(negedge clk); @(negedge clk); conv_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_conv(input logic a0_v);
    @(negedge clk); a0 = a0_v; convst_n = 1'b0;
    @(negedge clk); convst_n = 1'b1;
    check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
  endtask

  // rises first..last; decisions taken from offset binary of the codes
  task automatic edges(input int first, input int last, input int ca, input int cb);
    for (int k = first; k <= last; k++) begin
      int oa = ca ^ 'h800;
      int ob = cb ^ 'h800;
      if (k <= 12) cc_edge(oa[12-k], ob[12-k]);
      else         cc_edge(1'b1, 1'b1);  // R4 tail decisions ignored
      if (k == 15) check(busy === 1'b1, "R2 busy at rise 15", int'(busy), 1);
      if (k == 16) check(busy === 1'b0, "R2 busy cleared at rise 16", int'(busy), 0);
    end
  endtask

  task automatic do_read(input logic a0_v, input int exp, input string tag);
    @(negedge clk); a0 = a0_v; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(data_w === 12'(exp), tag, int'(data_w), exp);
    rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic is_released(input logic [11:0] v);
    return (v === 12'hzzz) || (v === 12'h000);
  endfunction

  task automatic t_reset;
    check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    do_read(1'b0, 'h000, "R1 pair0 A after reset");
    do_read(1'b1, 'h000, "R1 pair1 B after reset");
  endtask

  task automatic t_extremes;
    start_conv(1'b0);
    edges(1, 16, 'h7FF, 'h800);
    do_read(1'b0, 'h7FF, "R5 R7 first read A all-ones");
    do_read(1'b0, 'h800, "R5 R7 second read B all-zeros");
    do_read(1'b0, 'h7FF, "R7 third read wraps to A");
  endtask

  task automatic t_pair1;
    start_conv(1'b1);
    edges(1, 16, 'h000, 'hFFF);
    do_read(1'b1, 'h000, "R5 R9 pair1 A midscale");
    do_read(1'b1, 'hFFF, "R5 R9 pair1 B midscale-1");
    do_read(1'b0, 'h7FF, "R9 pair0 A retained");
    do_read(1'b0, 'h800, "R9 pair0 B retained");
  endtask

  task automatic t_bus_release;
    @(negedge clk); a0 = 1'b0; cs_n = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    check(is_released(data_w), "R6 cs low rd high", int'(data_w), 0);
    cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    check(is_released(data_w), "R6 rd low cs high", int'(data_w), 0);
    rd_n = 1'b1;
    @(negedge clk);
    check(is_released(data_w), "R6 both high", int'(data_w), 0);
    do_read(1'b0, 'h7FF, "R6 strobes without cs do not advance order");
    do_read(1'b0, 'h800, "R6 order then at B");
  endtask

  task automatic t_late_a0;
    start_conv(1'b1);
    @(negedge clk); a0 = 1'b0;
    edges(1, 16, 'h123, 'h5A5);
    do_read(1'b0, 'h123, "R3 R4 pair0 A from edge-time address");
    do_read(1'b0, 'h5A5, "R3 R4 pair0 B from edge-time address");
    do_read(1'b1, 'h000, "R3 pair1 A untouched");
    do_read(1'b1, 'hFFF, "R3 pair1 B untouched");
  endtask

  task automatic t_mid_read;
    do_read(1'b1, 'h000, "R8 pre-read A");
    start_conv(1'b1);
    edges(1, 6, 'h3C4, 'hC3B);
    do_read(1'b1, 'h000, "R8 R10 mid-conversion read A old");
    do_read(1'b1, 'hFFF, "R10 mid-conversion read B old");
    edges(7, 16, 'h3C4, 'hC3B);
    do_read(1'b1, 'h3C4, "R10 new pair1 A after end");
    do_read(1'b1, 'hC3B, "R10 new pair1 B after end");
    do_read(1'b0, 'h123, "R9 pair0 A retained");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_extremes();
    t_pair1();
    t_bus_release();
    t_late_a0();
    t_mid_read();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule